// File: doc/BRIEF.md
# Predicated Sub-Element Reversal Unit

This block is a vector datapath stage with its own instruction decoder. It accepts a 32-bit instruction word together with a source vector, the current contents of the destination vector and a predicate value that carries one bit per byte. Inside every active element of the source, it swaps the order of fixed-size sub-units (bytes, 16-bit halves or 32-bit words) end-for-end. The bit order inside each sub-unit stays as it was. The result is returned as the new destination vector.

Two fields of the instruction choose the element width and the swap granule independently. Combinations that make no sense, such as a granule that is not smaller than the element, are reported as undefined. An undefined instruction leaves the destination unchanged. A mode bit decides what happens to inactive elements: they either keep the previous destination value or are cleared. The vector length is a parameter. Every result appears exactly one clock after its input strobe, whatever the data or the predicate.

Top module: `subrev_unit`

## Requirements
- R1: An instruction word whose fixed bits differ from bits[31:24]=8'b00000101, bits[21:18]=4'b1001 or bits[15:14]=2'b10 is flagged undefined.
- R2: The granule field bits[17:16] selects 00 = 8-bit, 01 = 16-bit and 10 = 32-bit sub-units. The value 11 is flagged undefined.
- R3: The size field bits[23:22] gives an element width of 8<<size bits. The legal combinations are as follows. An 8-bit granule needs size != 00. A 16-bit granule needs size of 10 or 11. A 32-bit granule needs size 11. Every other combination is flagged undefined.
- R4: An element is active exactly when the predicate bit of its lowest-numbered byte is set. Predicate bit i belongs to byte i of the vector, and vector byte i is bits [8i+7:8i]. Predicate bits of the other bytes in the element are ignored.
- R5: In an active element of E bytes with granule G bytes, destination granule j (counted from the low end) receives source granule E/G-1-j of the same element. The bytes inside the granule keep their order.
- R6: When mode bit 13 is 0, inactive destination elements keep the previous destination value.
- R7: When mode bit 13 is 1, inactive destination elements become zero.
- R8: For an undefined instruction, undef_o is 1 and dst_o equals prev_i as presented with the strobe.
- R9: valid_o is high exactly one cycle after each valid_i, independent of data and predicate. Without a strobe, dst_o holds and undef_o is 0.
- R10: After reset, valid_o and undef_o are 0 and dst_o is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Input strobe: operands are valid this cycle |
| insn_i | input | 32 | Instruction word |
| src_i | input | VL | Source vector |
| prev_i | input | VL | Previous destination vector |
| pmask_i | input | VL/8 | Predicate, one bit per byte |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| undef_o | output | 1 | Instruction was undefined |
| dst_o | output | VL | New destination vector |

## Verification
Suppose the decoder's legality state is wrong. Then, in the cycle after the strobe, undef_o is flipped and dst_o either copies prev_i or shows a permuted value where the other was expected. A wrong element-size selection in the active-byte logic shows up only when predicate bits are set on non-lowest bytes of an element: whole elements are then permuted or kept when they should not be. A wrong swap pattern corrupts bytes inside active elements only, so each mismatch is visible on the same single result beat.

// File: rtl/subrev_pkg.sv
package subrev_pkg;

  typedef enum logic [1:0] {
    GRAN_B8  = 2'b00,
    GRAN_B16 = 2'b01,
    GRAN_B32 = 2'b10,
    GRAN_BAD = 2'b11
  } gran_e;

  typedef struct packed {
    logic       undef;
    logic       zero_mode;
    logic [1:0] size;
    gran_e      gran;
  } dec_t;

  localparam logic [7:0] FIX_TOP = 8'b0000_0101;
  localparam logic [3:0] FIX_MID = 4'b1001;
  localparam logic [1:0] FIX_LOW = 2'b10;

  // legal pairing of element size and swap granule
  function automatic logic combo_legal(logic [1:0] size, gran_e g);
    case (g)
      GRAN_B8:  return size != 2'b00;
      GRAN_B16: return size[1];
      GRAN_B32: return size == 2'b11;
      default:  return 1'b0;
    endcase
  endfunction

  // byte-offset mask inside one element (element bytes minus one)
  function automatic logic [2:0] elem_mask(logic [1:0] size);
    return 3'((4'd1 << size) - 4'd1);
  endfunction

  // byte-offset mask inside one granule
  function automatic logic [2:0] gran_mask(gran_e g);
    case (g)
      GRAN_B8:  return 3'b000;
      GRAN_B16: return 3'b001;
      GRAN_B32: return 3'b011;
      default:  return 3'b111;
    endcase
  endfunction

  // reversing power-of-two granules inside a power-of-two element
  // equals flipping the granule-index bits of the byte offset
  function automatic logic [2:0] swap_xor(logic [1:0] size, gran_e g);
    return elem_mask(size) & ~gran_mask(g);
  endfunction

endpackage

// File: rtl/subrev_decode.sv
module subrev_decode
  import subrev_pkg::*;
(
  input  logic [31:0] insn_i,
  output dec_t        dec_o
);
  logic fixed_ok;
  logic unused_fields;

  assign fixed_ok = (insn_i[31:24] == FIX_TOP) &&
                    (insn_i[21:18] == FIX_MID) &&
                    (insn_i[15:14] == FIX_LOW);

  assign unused_fields = ^insn_i[12:0];

  always_comb begin
    dec_o.size      = insn_i[23:22];
    dec_o.gran      = gran_e'(insn_i[17:16]);
    dec_o.zero_mode = insn_i[13];
    dec_o.undef     = !fixed_ok || !combo_legal(insn_i[23:22], gran_e'(insn_i[17:16]));
  end
endmodule

// File: rtl/subrev_active.sv
module subrev_active #(
  parameter int NB = 32
) (
  input  logic [1:0]    size_i,
  input  logic [NB-1:0] pmask_i,
  output logic [NB-1:0] act_o
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam int B2 = b - (b % 2);
    localparam int B4 = b - (b % 4);
    localparam int B8 = b - (b % 8);
    always_comb begin
      case (size_i)
        2'd0:    act_o[b] = pmask_i[b];
        2'd1:    act_o[b] = pmask_i[B2];
        2'd2:    act_o[b] = pmask_i[B4];
        default: act_o[b] = pmask_i[B8];
      endcase
    end
  end
endmodule

// File: rtl/subrev_permute.sv
module subrev_permute #(
  parameter int NB = 32
) (
  input  logic [NB*8-1:0] data_i,
  input  logic [2:0]      sel_i,
  output logic [NB*8-1:0] data_o
);
  localparam int GROUP = 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [GROUP-1:0][7:0] cand;
    for (genvar k = 0; k < GROUP; k++) begin : g_cand
      localparam int SRC = b ^ k;
      assign cand[k] = data_i[SRC*8 +: 8];
    end
    assign data_o[b*8 +: 8] = cand[sel_i];
  end
endmodule

// File: rtl/subrev_unit.sv
module subrev_unit
  import subrev_pkg::*;
#(
  parameter int VL = 256
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [31:0]    insn_i,
  input  logic [VL-1:0]  src_i,
  input  logic [VL-1:0]  prev_i,
  input  logic [VL/8-1:0] pmask_i,
  output logic           valid_o,
  output logic           undef_o,
  output logic [VL-1:0]  dst_o
);
  localparam int NB = VL / 8;

  if ((VL % 128) != 0 || VL < 128 || VL > 2048) begin : g_bad_vl
    $error("subrev_unit: VL must be a multiple of 128 within 128..2048");
  end

  dec_t           dec;
  logic           dec_undef;
  logic [2:0]     swap_sel;
  logic [NB-1:0]  act;
  logic [VL-1:0]  perm;
  logic [VL-1:0]  merged;
  logic [VL-1:0]  nxt;

  subrev_decode u_dec (
    .insn_i (insn_i),
    .dec_o  (dec)
  );

  assign dec_undef = dec.undef;
  assign swap_sel  = swap_xor(dec.size, dec.gran);

  subrev_active #(.NB(NB)) u_act (
    .size_i  (dec.size),
    .pmask_i (pmask_i),
    .act_o   (act)
  );

  subrev_permute #(.NB(NB)) u_perm (
    .data_i (src_i),
    .sel_i  (swap_sel),
    .data_o (perm)
  );

  for (genvar b = 0; b < NB; b++) begin : g_merge
    always_comb begin
      if (act[b])             merged[b*8 +: 8] = perm[b*8 +: 8];
      else if (dec.zero_mode) merged[b*8 +: 8] = 8'h00;
      else                    merged[b*8 +: 8] = prev_i[b*8 +: 8];
    end
  end

  assign nxt = dec_undef ? prev_i : merged;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      undef_o <= 1'b0;
      dst_o   <= '0;
    end else begin
      valid_o <= valid_i;
      undef_o <= valid_i && dec_undef;
      if (valid_i) dst_o <= nxt;
    end
  end
endmodule

// File: rtl/subrev_unit_chk.sv
module subrev_unit_chk #(
  parameter int VL = 256
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [31:0]     insn_i,
  input logic [VL-1:0]   prev_i,
  input logic [VL/8-1:0] pmask_i,
  input logic            valid_o,
  input logic            undef_o,
  input logic [VL-1:0]   dst_o,
  input logic            dec_undef
);
  // R9
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R9
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !undef_o));

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(dst_o));

  // R1
  fixed_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (insn_i[31:24] != 8'b0000_0101 || insn_i[21:18] != 4'b1001 ||
                 insn_i[15:14] != 2'b10)) |=> undef_o);

  // R2
  gran_bad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && insn_i[17:16] == 2'b11) |=> undef_o);

  // R8
  undef_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dec_undef) |=> (undef_o && dst_o == $past(prev_i)));

  // R7
  zero_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dec_undef && insn_i[13] && pmask_i == '0) |=> (dst_o == '0));

  // R6
  merge_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dec_undef && !insn_i[13] && pmask_i == '0) |=> (dst_o == $past(prev_i)));
endmodule

bind subrev_unit subrev_unit_chk #(.VL(VL)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .insn_i    (insn_i),
  .prev_i    (prev_i),
  .pmask_i   (pmask_i),
  .valid_o   (valid_o),
  .undef_o   (undef_o),
  .dst_o     (dst_o),
  .dec_undef (dec_undef)
);

// File: tb/subrev_unit_tb.sv
module subrev_unit_tb;
  localparam int VL = 256;
  localparam int NB = VL / 8;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [31:0]     insn_i = '0;
  logic [VL-1:0]   src_i = '0;
  logic [VL-1:0]   prev_i = '0;
  logic [NB-1:0]   pmask_i = '0;
  logic            valid_o;
  logic            undef_o;
  logic [VL-1:0]   dst_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  subrev_unit #(.VL(VL)) u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .insn_i  (insn_i),
    .src_i   (src_i),
    .prev_i  (prev_i),
    .pmask_i (pmask_i),
    .valid_o (valid_o),
    .undef_o (undef_o),
    .dst_o   (dst_o)
  );

  typedef struct {
    logic          undef;
    logic [VL-1:0] vec;
    string         tag;
  } exp_t;

  exp_t          sb[$];
  int            checks = 0;
  int            errors = 0;
  logic [VL-1:0] last_vec = '0;
  bit            done = 0;

  function automatic logic [VL-1:0] rvec();
    logic [VL-1:0] v;
    for (int i = 0; i < VL / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [NB-1:0] rpred();
    logic [NB-1:0] p;
    for (int i = 0; i < NB; i++) p[i] = 1'($urandom);
    return p;
  endfunction

  function automatic logic [31:0] mk(logic [1:0] sz, logic [1:0] op, logic z);
    logic [12:0] regs;
    regs = 13'($urandom);
    return {8'b0000_0101, sz, 4'b1001, op, 2'b10, z, regs};
  endfunction

  // reference: walks elements and granules explicitly
  function automatic exp_t model(logic [31:0] ins, logic [VL-1:0] src,
                                 logic [VL-1:0] old, logic [NB-1:0] pr, string tag);
    exp_t r;
    int sz, op, eb, gb, ng;
    bit legal;
    r.tag = tag;
    sz = int'(ins[23:22]);
    op = int'(ins[17:16]);
    legal = (ins[31:24] == 8'h05) && (ins[21:18] == 4'b1001) && (ins[15:14] == 2'b10);
    case (op)
      0: legal = legal && (sz >= 1);
      1: legal = legal && (sz >= 2);
      2: legal = legal && (sz == 3);
      default: legal = 0;
    endcase
    if (!legal) begin
      r.undef = 1'b1;
      r.vec = old;
      return r;
    end
    r.undef = 1'b0;
    eb = 1 << sz;
    gb = 1 << op;
    ng = eb / gb;
    r.vec = ins[13] ? '0 : old;
    for (int e = 0; e < NB / eb; e++) begin
      if (pr[e*eb]) begin
        for (int j = 0; j < ng; j++)
          for (int k = 0; k < gb; k++)
            r.vec[8*(e*eb + j*gb + k) +: 8] = src[8*(e*eb + (ng-1-j)*gb + k) +: 8];
      end
    end
    return r;
  endfunction

  task automatic drive(logic [31:0] ins, logic [VL-1:0] src, logic [VL-1:0] old,
                       logic [NB-1:0] pr, string tag);
    @(negedge clk_i);
    valid_i = 1'b1;
    insn_i  = ins;
    src_i   = src;
    prev_i  = old;
    pmask_i = pr;
    sb.push_back(model(ins, src, old, pr, tag));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      src_i   = rvec();
      prev_i  = rvec();
      insn_i  = $urandom;
      pmask_i = rpred();
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (valid_o) begin
        exp_t e;
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R9: result beat with no pending item, got undef=%0b", undef_o);
        end else begin
          e = sb.pop_front();
          if (undef_o !== e.undef || dst_o !== e.vec) begin
            errors++;
            $display("FAIL %s: undef=%0b dst=%h expected undef=%0b dst=%h",
                     e.tag, undef_o, dst_o, e.undef, e.vec);
          end
          last_vec = e.vec;
        end
      end else if (!done) begin
        // R9: idle cycle holds the last result and shows no undef
        checks++;
        if (dst_o !== last_vec || undef_o !== 1'b0) begin
          errors++;
          $display("FAIL R9: idle dst=%h undef=%0b expected dst=%h undef=0",
                   dst_o, undef_o, last_vec);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, pending=%0d expected 0", sb.size());
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] ones;
    ones = '1;
    repeat (3) @(negedge clk_i);
    // R10: reset state
    checks++;
    if (valid_o !== 1'b0 || undef_o !== 1'b0 || dst_o !== '0) begin
      errors++;
      $display("FAIL R10: valid=%0b undef=%0b dst=%h expected 0 0 0", valid_o, undef_o, dst_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(2);

    // R1: each fixed field disturbed
    drive(mk(2'd3, 2'd0, 1'b0) ^ 32'h8000_0000, rvec(), rvec(), ones, "R1");
    drive(mk(2'd3, 2'd0, 1'b0) ^ 32'h0004_0000, rvec(), rvec(), ones, "R1");
    drive(mk(2'd3, 2'd0, 1'b1) ^ 32'h0000_4000, rvec(), rvec(), ones, "R1");
    drive(mk(2'd3, 2'd0, 1'b1) ^ 32'h0100_0000, rvec(), rvec(), ones, "R1");
    idle(1);

    // R2: reserved granule code
    for (int s = 0; s < 4; s++) drive(mk(2'(s), 2'd3, 1'(s)), rvec(), rvec(), ones, "R2");
    idle(1);

    // R3: every size/granule pairing, both modes
    for (int o = 0; o < 3; o++)
      for (int s = 0; s < 4; s++)
        for (int z = 0; z < 2; z++)
          drive(mk(2'(s), 2'(o), 1'(z)), rvec(), rvec(), rpred(), "R3");
    idle(2);

    // R5: all active, every legal pairing
    for (int o = 0; o < 3; o++)
      for (int s = 1; s < 4; s++)
        drive(mk(2'(s), 2'(o), 1'($urandom)), rvec(), rvec(), ones, "R5");
    idle(1);

    // R6 / R7: all inactive and all active in both modes
    drive(mk(2'd3, 2'd0, 1'b0), rvec(), rvec(), '0, "R6");
    drive(mk(2'd1, 2'd0, 1'b0), rvec(), rvec(), ones, "R6");
    drive(mk(2'd3, 2'd2, 1'b1), rvec(), rvec(), '0, "R7");
    drive(mk(2'd2, 2'd1, 1'b1), rvec(), rvec(), ones, "R7");
    idle(1);

    // R4: only non-lowest bytes set -> every wider element inactive
    for (int s = 1; s < 4; s++) begin
      drive(mk(2'(s), 2'd0, 1'b1), rvec(), rvec(), ~{(NB/2){2'b01}}, "R4");
      drive(mk(2'(s), 2'd0, 1'b0), rvec(), rvec(), {(NB/2){2'b01}}, "R4");
    end
    idle(1);

    // R8: undefined keeps the old destination
    drive(mk(2'd0, 2'd0, 1'b1), rvec(), rvec(), ones, "R8");
    drive(mk(2'd2, 2'd2, 1'b1), rvec(), rvec(), '0, "R8");
    idle(3);

    // R9: random stream with random gaps; R4/R5 over random data
    for (int n = 0; n < 400; n++) begin
      drive(mk(2'($urandom), 2'($urandom_range(0, 2)), 1'($urandom)),
            rvec(), rvec(), rpred(), "R5");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(3);
    done = 1;
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R9: %0d results missing expected 0", sb.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule